// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a small set of asynchronous external interrupt pins and turns each into an active-high level request for a parent interrupt controller. Each pin has its own 2-bit detection mode: low level, falling edge, rising edge, or both edges. Every pin passes through a two-stage synchronizer. A detected event sets a sticky pending flag, and that flag drives the pin's request line.

Software reaches the block through a plain 32-bit register port with one write strobe and a combinational read path. Two registers are mapped. The mode register holds all the 2-bit fields. The pending register holds one flag per pin. A pending flag is cleared by writing 0 to its bit position, and writing 1 leaves that flag as it is. The request vector is zero-based: request bit n goes to parent line n+1.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset every mode field reads 0, every pending flag reads 0 and every request output is low.
- R2: The mode register at byte offset 0x14 holds the field for pin n in bits [2n+1:2n]. A write stores bits [15:0], and a read returns them with bits [31:16] reading zero.
- R3: Mode 1 (falling edge) sets pin n's pending flag after a high-to-low transition of the pin. A low-to-high transition does not set it.
- R4: Mode 2 (rising edge) sets the pending flag after a low-to-high transition. A high-to-low transition does not set it.
- R5: Mode 3 (both edges) sets the pending flag after a transition in either direction.
- R6: Mode 0 (low level) sets the pending flag while the synchronized pin is low. A clear issued while the pin is still low leaves the flag set.
- R7: The pending register at byte offset 0x10 shows pin n at bit n. A write clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged.
- R8: Once set, a pending flag stays set after the pin returns to its idle level, until software clears it.
- R9: Request output bit n is active high and equals pending flag n, whatever mode is selected. Bit n feeds parent request line n+1.
- R10: Any offset other than 0x10 and 0x14 reads as zero, and writes to such offsets change no register.
- R11: An event detected in the same cycle as a clear of that flag wins, and the flag ends up set.
- R12: A pin change reaches the pending flag on the third rising clock edge after the change: two synchronizer stages, then the flag register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | 8 | Asynchronous external interrupt pins |
| regAddr | input | 8 | Register byte offset |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| irqReq | output | 8 | Active-high level requests to the parent controller |

## Verification
The assertions assume that regAddr, regWrEn and regWrData are stable around each rising edge, and that pins are held at their idle high level while reset is asserted. The stimulus drives all register inputs on falling edges only. It keeps every pin high during and just after reset, and changes a pin only on a falling edge with at least four clock cycles before the next check. This keeps each expected value tied to a known synchronizer latency. The one exception is the deliberate clear-versus-event collision, which is placed on an exactly counted edge.

// File: rtl/ext_irq_sense_pkg.sv
package ext_irq_sense_pkg;
  localparam logic [7:0] STATUS_OFF = 8'h10;
  localparam logic [7:0] SENSE_OFF  = 8'h14;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_RISE = 2'd2,
    SENSE_BOTH = 2'd3
  } senseMode_t;

  typedef struct packed {
    logic senseWr;
    logic statusWr;
    logic senseRd;
    logic statusRd;
  } regStrobe_t;
endpackage

// File: rtl/ext_irq_sense_ctrl.sv
module ext_irq_sense_ctrl
  import ext_irq_sense_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regWrEn,
  input  logic [2*NUM_PINS-1:0] senseVal,
  input  logic [NUM_PINS-1:0]   statusVal,
  output regStrobe_t            strobe,
  output logic [DATA_W-1:0]     regRdData
);
  localparam logic [ADDR_W-1:0] SenseAddr  = ADDR_W'(SENSE_OFF);
  localparam logic [ADDR_W-1:0] StatusAddr = ADDR_W'(STATUS_OFF);

  logic hitSense;
  logic hitStatus;

  assign hitSense  = (regAddr == SenseAddr);
  assign hitStatus = (regAddr == StatusAddr);

  always_comb begin
    strobe.senseWr  = regWrEn && hitSense;
    strobe.statusWr = regWrEn && hitStatus;
    strobe.senseRd  = hitSense;
    strobe.statusRd = hitStatus;
  end

  always_comb begin
    regRdData = '0;
    if (strobe.senseRd)  regRdData = DATA_W'(senseVal);
    if (strobe.statusRd) regRdData = DATA_W'(statusVal);
  end
endmodule

// File: rtl/ext_irq_sense_dp.sv
module ext_irq_sense_dp
  import ext_irq_sense_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DATA_W   = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_PINS-1:0]   pinIn,
  input  regStrobe_t            strobe,
  input  logic [DATA_W-1:0]     wrData,
  output logic [2*NUM_PINS-1:0] senseVal,
  output logic [NUM_PINS-1:0]   statusVal
);
  localparam int SenseW = 2 * NUM_PINS;

  logic [NUM_PINS-1:0] syncA;
  logic [NUM_PINS-1:0] syncB;
  logic [NUM_PINS-1:0] syncPrev;
  logic [SenseW-1:0]   senseReg;
  logic [NUM_PINS-1:0] statusReg;
  logic [NUM_PINS-1:0] setMask;
  logic [NUM_PINS-1:0] clearMask;

  // Pins idle high; the synchronizer resets to that level so no false edge or
  // low-level hit appears right after reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= '1;
      syncB    <= '1;
      syncPrev <= '1;
    end else begin
      syncA    <= pinIn;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              senseReg <= '0;
    else if (strobe.senseWr) senseReg <= wrData[SenseW-1:0];
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_detect
    senseMode_t mode;
    logic       hit;
    assign mode = senseMode_t'(senseReg[2*g +: 2]);
    always_comb begin
      unique case (mode)
        SENSE_LOW:  hit = !syncB[g];
        SENSE_FALL: hit = syncPrev[g] && !syncB[g];
        SENSE_RISE: hit = !syncPrev[g] && syncB[g];
        SENSE_BOTH: hit = syncPrev[g] ^ syncB[g];
        default:    hit = 1'b0;
      endcase
    end
    assign setMask[g] = hit;
  end

  assign clearMask = strobe.statusWr ? ~wrData[NUM_PINS-1:0] : '0;

  // A new event takes priority over a clear in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusReg <= '0;
    else       statusReg <= (statusReg & ~clearMask) | setMask;
  end

  assign senseVal  = senseReg;
  assign statusVal = statusReg;
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_sense_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  output logic [NUM_PINS-1:0] irqReq
);
  regStrobe_t                strobe;
  logic [2*NUM_PINS-1:0]     senseVal;
  logic [NUM_PINS-1:0]       statusVal;

  ext_irq_sense_ctrl #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .senseVal  (senseVal),
    .statusVal (statusVal),
    .strobe    (strobe),
    .regRdData (regRdData)
  );

  ext_irq_sense_dp #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .pinIn     (pinIn),
    .strobe    (strobe),
    .wrData    (regWrData),
    .senseVal  (senseVal),
    .statusVal (statusVal)
  );

  assign irqReq = statusVal;
endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk
  import ext_irq_sense_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   regAddr,
  input logic                regWrEn,
  input logic [DATA_W-1:0]   regWrData,
  input logic [DATA_W-1:0]   regRdData,
  input logic [NUM_PINS-1:0] irqReq
);
  localparam logic [ADDR_W-1:0] SenseAddr  = ADDR_W'(SENSE_OFF);
  localparam logic [ADDR_W-1:0] StatusAddr = ADDR_W'(STATUS_OFF);
  localparam int SenseW = 2 * NUM_PINS;

  assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (irqReq == '0));

  assert_sense_readback_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == SenseAddr) |=>
      (regAddr != SenseAddr || regRdData == DATA_W'($past(regWrData[SenseW-1:0]))));

  assert_write_one_keeps_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == StatusAddr) |=>
      ((irqReq & $past(irqReq & regWrData[NUM_PINS-1:0])) == $past(irqReq & regWrData[NUM_PINS-1:0])));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == StatusAddr) |=> ((irqReq & $past(irqReq)) == $past(irqReq)));

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr != SenseAddr && regAddr != StatusAddr) |-> (regRdData == '0));

  assert_status_mirror_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == StatusAddr) |-> (regRdData == DATA_W'(irqReq)));
endmodule

bind ext_irq_sense ext_irq_sense_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .irqReq    (irqReq)
);

// File: tb/ext_irq_sense_bench.sv
module ext_irq_sense_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  pinIn = 8'hFF;
  logic [7:0]  regAddr = 8'h00;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [7:0]  irqReq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_sense u_ext_irq_sense (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData), .irqReq(irqReq)
  );

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 8'h00;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkStatus(input string req, input logic [7:0] exp);
    logic [31:0] rd;
    regRead(8'h10, rd);
    check32(req, rd, {24'h0, exp});
    check32({req, "/R9"}, {24'h0, irqReq}, {24'h0, exp});
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(3);

    // R1 reset state
    regRead(8'h14, rd);
    check32("R1 sense", rd, 32'h0);
    checkStatus("R1 status", 8'h00);

    // R2 readback patterns and field positions
    regWrite(8'h14, 32'hFFFF_1B2D);
    regRead(8'h14, rd);
    check32("R2 upper zero", rd, 32'h0000_1B2D);
    regWrite(8'h14, 32'h0000_E4C9);
    regRead(8'h14, rd);
    check32("R2 pattern", rd, 32'h0000_E4C9);

    // R10 unmapped reads and writes
    regWrite(8'h18, 32'hFFFF_FFFF);
    regWrite(8'h00, 32'hFFFF_FFFF);
    regRead(8'h14, rd);
    check32("R10 write ignored", rd, 32'h0000_E4C9);
    for (int a = 0; a < 64; a += 4) begin
      if (a != 16 && a != 20) begin
        regRead(8'(a), rd);
        check32("R10 read zero", rd, 32'h0);
      end
    end

    // Sweep every pin through every mode (R3 R4 R5 R6 R7 R8 R12)
    for (int p = 0; p < NP; p++) begin
      for (int m = 0; m < 4; m++) begin
        logic [15:0] sw;
        logic [7:0]  bitP;
        bitP = 8'(1 << p);
        sw = (16'hAAAA & ~(16'h3 << (2*p))) | (16'(m) << (2*p));
        regWrite(8'h14, {16'h0, sw});
        waitCyc(2);
        regWrite(8'h10, 32'h0);
        waitCyc(4);
        checkStatus("R7 idle clear", 8'h00);
        // falling edge: R12 pin change visible after three edges
        @(negedge clk); pinIn[p] = 1'b0;
        waitCyc(4);
        checkStatus(m == 1 ? "R3 fall" : m == 2 ? "R4 no fall" : m == 3 ? "R5 fall" : "R6 low",
                    (m != 2) ? bitP : 8'h00);
        // clear while pin stays low
        regWrite(8'h10, 32'h0);
        waitCyc(2);
        checkStatus(m == 0 ? "R6 clear while low" : "R7 clear", (m == 0) ? bitP : 8'h00);
        // rising edge
        @(negedge clk); pinIn[p] = 1'b1;
        waitCyc(4);
        checkStatus(m == 1 ? "R3 no rise" : m == 2 ? "R4 rise" : m == 3 ? "R5 rise" : "R8 level sticky",
                    (m != 1) ? bitP : 8'h00);
        regWrite(8'h10, 32'h0);
        waitCyc(2);
        checkStatus("R7 final clear", 8'h00);
      end
    end

    // R12 latency: not yet set after two edges, set after three
    regWrite(8'h14, 32'h0000_AAA9);   // pin0 falling
    waitCyc(2);
    @(negedge clk); pinIn[0] = 1'b0;
    @(negedge clk); @(negedge clk); #1;
    check32("R12 before third edge", {24'h0, irqReq}, 32'h0);
    @(negedge clk); #1;
    check32("R12 after third edge", {24'h0, irqReq}, 32'h1);
    @(negedge clk); pinIn[0] = 1'b1;
    waitCyc(4);

    // R7 write-one keeps: set pins 0 and 1 via falling edges
    regWrite(8'h14, 32'h0000_AAA5);
    waitCyc(2);
    regWrite(8'h10, 32'h0);
    @(negedge clk); pinIn[1:0] = 2'b00;
    waitCyc(4);
    checkStatus("R7 two set", 8'h03);
    regWrite(8'h10, 32'hFFFF_FFFE);
    checkStatus("R7 write one keeps", 8'h02);
    @(negedge clk); pinIn[1:0] = 2'b11;
    waitCyc(4);
    regWrite(8'h10, 32'h0);
    checkStatus("R7 cleared", 8'h00);

    // R11 clear collides with a falling event on pin 2
    regWrite(8'h14, 32'h0000_AA9A);   // pin2 falling
    waitCyc(2);
    regWrite(8'h10, 32'h0);
    waitCyc(2);
    @(negedge clk); pinIn[2] = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); regAddr = 8'h10; regWrData = 32'h0; regWrEn = 1'b1;
    @(negedge clk); regWrEn = 1'b0; regAddr = 8'h00;
    checkStatus("R11 event wins over clear", 8'h04);
    @(negedge clk); pinIn[2] = 1'b1;
    waitCyc(4);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule